// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block turns one external interrupt pad into a latched status flag and an interrupt request toward the processor. The pad input is asynchronous to the core clock. It passes through a flop-chain synchronizer. The synchronized level is then compared with its previous sample to find the moment the pin moves into its asserted level. Software chooses which level counts as asserted: high (with rising edges) or low (with falling edges). It also chooses whether only that transition sets the flag, or whether the flag is also held set for as long as the pin stays asserted.

Software clears the flag with a one-cycle strobe. A request reaches the processor only while both the pin enable and the local interrupt enable are set. With the interrupt enable clear, the flag is still set and can be polled. The block also reports the synchronized raw pin level, so software can test the pin directly. It produces a purely combinational wake signal that still works while the core clock is stopped. Two output bits drive the pad's internal pull device, and the pull direction follows the chosen polarity.

Top module: `extint_detect`

## Requirements
- R1: After a clock edge with `rst_n` low, `flag_o`, `irq_o` and `pin_lvl_o` are 0.
- R2: While `pin_en_i` is 0, no pin activity sets `flag_o`, and `irq_o`, `wake_o`, `pull_up_o` and `pull_dn_o` are all 0.
- R3: `pin_lvl_o` shows the pin level two clock edges after the pin changes. A qualifying transition makes `flag_o` read 1 after the third clock edge, and not earlier.
- R4: With `pol_hi_i`=1 the asserted level is high and a 0-to-1 transition is the event. With `pol_hi_i`=0 the asserted level is low and a 1-to-0 transition is the event.
- R5: With `mode_lvl_i`=0 (edge only), the flag stays set after the pin returns to the deasserted level. Once it is cleared, a pin that is still held asserted does not set it again.
- R6: With `mode_lvl_i`=1 (edge and level), the flag is held at 1 and a clear strobe has no effect while the synchronized pin is asserted. Once the pin is deasserted, a clear strobe works.
- R7: A `flag_clr_i` pulse sampled at a clock edge makes `flag_o` read 0 after that edge. If a set condition is present at the same edge, the flag stays 1 (set wins).
- R8: `irq_o` is 1 exactly when `flag_o`, `irq_en_i` and `pin_en_i` are all 1. It follows changes of the two enables without a clock edge.
- R9: The edge history is held deasserted while the pin is disabled. Enabling the pin while it sits at its asserted level therefore sets the flag one clock edge later.
- R10: `wake_o` is combinational from `pin_i`. It is 1 whenever the pin is enabled and the raw pin is at its asserted level, with no clock edge needed.
- R11: With the pin enabled and `pull_dis_i`=0, `pull_up_o` is 1 for `pol_hi_i`=0 and `pull_dn_o` is 1 for `pol_hi_i`=1. `pull_dis_i`=1 forces both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 1 | Raw external interrupt pad, asynchronous |
| pin_en_i | input | 1 | Pin acts as interrupt input when 1 |
| pol_hi_i | input | 1 | 1: rising/high asserted, 0: falling/low asserted |
| mode_lvl_i | input | 1 | 0: edge only, 1: edge and level |
| irq_en_i | input | 1 | Local interrupt enable |
| pull_dis_i | input | 1 | 1 disables the internal pull device |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| flag_o | output | 1 | Latched interrupt status flag |
| irq_o | output | 1 | Request to the processor |
| pin_lvl_o | output | 1 | Synchronized raw pin level |
| wake_o | output | 1 | Asynchronous wake from asserted enabled pin |
| pull_up_o | output | 1 | Internal pull-up enable |
| pull_dn_o | output | 1 | Internal pull-down enable |

## Verification
The hardest case to reach from the ports is a clear strobe that lands on the same clock edge as a freshly detected edge. The event is only visible inside the one cycle between the second and third synchronizer edges. The bench drives the pin at a falling clock edge, lets exactly two rising edges pass, and then raises the clear strobe for one cycle. It expects the flag to survive. The pinned flag in edge-and-level mode is reached by holding the pin asserted across repeated clear strobes. The bench then clears again after exactly two edges following release, which is the first edge at which the synchronized level has dropped.

// File: rtl/extint_pkg.sv
// Shared definitions for the external interrupt pin detector.
package extint_pkg;
    // Detection mode selected by the mode input.
    typedef enum logic {
        DET_EDGE       = 1'b0,
        DET_EDGE_LEVEL = 1'b1
    } det_mode_e;

    // Default synchronizer depth; two flops is the minimum accepted.
    localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/extint_sync.sv
// Flop-chain synchronizer for the asynchronous pad input.
// Assumes STAGES >= 2; output lags the pad by STAGES clock edges.
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the raw pad.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign pin_sync_o = chain_q[LAST];
endmodule

// File: rtl/extint_edge.sv
// Polarity normalisation and assertion-edge detection.
// The previous-sample register is forced deasserted while the pin is
// disabled, so enabling an already asserted pin counts as an edge.
module extint_edge
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync_i,
    input  logic pin_en_i,
    input  logic pol_hi_i,
    input  logic mode_lvl_i,
    output logic asserted_o,
    output logic set_o
);
    det_mode_e mode;
    logic      prev_q;
    logic      rise;

    // Map the synchronized level onto "asserted" for the chosen polarity.
    always_comb begin
        mode       = det_mode_e'(mode_lvl_i);
        asserted_o = pol_hi_i ? pin_sync_i : ~pin_sync_i;
    end

    // Remember the last asserted state; held low while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_q <= 1'b0;
        else if (!pin_en_i) prev_q <= 1'b0;
        else                prev_q <= asserted_o;
    end

    // Set on a deasserted-to-asserted move, or on a held level in level mode.
    always_comb begin
        rise  = asserted_o & ~prev_q;
        set_o = 1'b0;
        if (pin_en_i) begin
            if (mode == DET_EDGE_LEVEL) set_o = rise | asserted_o;
            else                        set_o = rise;
        end
    end
endmodule

// File: rtl/extint_flag.sv
// Status flag register: the set request wins over the clear strobe.
module extint_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold, clear on strobe, set on event (set has priority).
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/extint_detect.sv
// External interrupt pin detector top level.
// Synchronizes the pad, detects assertion events, latches a flag, gates the
// processor request, and drives wake and pull-control outputs.
// Assumes flag_clr_i is a single-cycle pulse in the core clock domain.
module extint_detect
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pin_en_i,
    input  logic pol_hi_i,
    input  logic mode_lvl_i,
    input  logic irq_en_i,
    input  logic pull_dis_i,
    input  logic flag_clr_i,
    output logic flag_o,
    output logic irq_o,
    output logic pin_lvl_o,
    output logic wake_o,
    output logic pull_up_o,
    output logic pull_dn_o
);
    logic pin_sync;
    logic asserted_lvl;
    logic set_evt;
    logic pull_on;

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .pin_sync_o (pin_sync)
    );

    extint_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sync_i (pin_sync),
        .pin_en_i   (pin_en_i),
        .pol_hi_i   (pol_hi_i),
        .mode_lvl_i (mode_lvl_i),
        .asserted_o (asserted_lvl),
        .set_o      (set_evt)
    );

    extint_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_evt),
        .clr_i  (flag_clr_i),
        .flag_o (flag_o)
    );

    // Request, readout, clockless wake path and pull-device control.
    always_comb begin
        irq_o     = flag_o & irq_en_i & pin_en_i;
        pin_lvl_o = pin_sync;
        wake_o    = pin_en_i & (pol_hi_i ? pin_i : ~pin_i);
        pull_on   = pin_en_i & ~pull_dis_i;
        pull_up_o = pull_on & ~pol_hi_i;
        pull_dn_o = pull_on & pol_hi_i;
    end
endmodule

// File: rtl/extint_detect_chk.sv
// Property checker for extint_detect, attached with bind below.
module extint_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic pin_en_i,
    input logic mode_lvl_i,
    input logic flag_clr_i,
    input logic flag_o,
    input logic irq_o,
    input logic wake_o,
    input logic set_evt,
    input logic asserted_lvl
);
    // R2: a disabled pin never raises a clear flag.
    a_r2_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_en_i && !flag_o) |=> !flag_o);

    // R2 / R10: wake requires the pin enable.
    a_r10_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> pin_en_i);

    // R8: no request without a flag.
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R7: clear strobe without a set event empties the flag.
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !set_evt) |=> !flag_o);

    // R7: a set event always lands, even against a clear.
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_o);

    // R6: held asserted level in level mode pins the flag.
    a_r6_level_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en_i && mode_lvl_i && asserted_lvl) |=> flag_o);

    // R5: without a clear the flag holds.
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);
endmodule

bind extint_detect extint_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_en_i     (pin_en_i),
    .mode_lvl_i   (mode_lvl_i),
    .flag_clr_i   (flag_clr_i),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .wake_o       (wake_o),
    .set_evt      (set_evt),
    .asserted_lvl (asserted_lvl)
);

// File: tb/extint_detect_tb.sv
// Directed bench: inputs change and outputs are sampled at falling edges.
module extint_detect_tb;
    logic clk = 1'b0;
    logic rst_n, pin, pin_en, pol_hi, mode_lvl, irq_en, pull_dis, flag_clr;
    logic flag, irq, pin_lvl, wake, pull_up, pull_dn;
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #10 clk = ~clk;

    extint_detect u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_en_i(pin_en),
        .pol_hi_i(pol_hi), .mode_lvl_i(mode_lvl), .irq_en_i(irq_en),
        .pull_dis_i(pull_dis), .flag_clr_i(flag_clr),
        .flag_o(flag), .irq_o(irq), .pin_lvl_o(pin_lvl), .wake_o(wake),
        .pull_up_o(pull_up), .pull_dn_o(pull_dn)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "flag after reset", flag, 1'b0);
        chk("R1", "irq after reset", irq, 1'b0);
        chk("R1", "pin_lvl after reset", pin_lvl, 1'b0);
    endtask

    task automatic t_disabled();
        pin_en = 1'b0; pol_hi = 1'b1; pin = 1'b1; #1;
        chk("R2", "wake while disabled", wake, 1'b0);
        chk("R2", "pull_up while disabled", pull_up, 1'b0);
        chk("R2", "pull_dn while disabled", pull_dn, 1'b0);
        tick(4);
        chk("R2", "flag while disabled", flag, 1'b0);
        chk("R2", "irq while disabled", irq, 1'b0);
        pin = 1'b0; tick(3);
    endtask

    task automatic t_pull();
        pin_en = 1'b1; pol_hi = 1'b0; pull_dis = 1'b0; #1;
        chk("R11", "pull_up low polarity", pull_up, 1'b1);
        chk("R11", "pull_dn low polarity", pull_dn, 1'b0);
        pol_hi = 1'b1; #1;
        chk("R11", "pull_dn high polarity", pull_dn, 1'b1);
        chk("R11", "pull_up high polarity", pull_up, 1'b0);
        pull_dis = 1'b1; #1;
        chk("R11", "pull_dn disabled", pull_dn, 1'b0);
        pull_dis = 1'b0;
        tick(4); clear_flag(); tick(1);
    endtask

    task automatic t_rising_latency();
        pol_hi = 1'b1; mode_lvl = 1'b0; pin = 1'b1; #1;
        chk("R10", "wake combinational rising", wake, 1'b1);
        tick(1);
        chk("R3", "pin_lvl after 1 edge", pin_lvl, 1'b0);
        tick(1);
        chk("R3", "pin_lvl after 2 edges", pin_lvl, 1'b1);
        chk("R3", "flag after 2 edges", flag, 1'b0);
        tick(1);
        chk("R4", "flag on rising edge", flag, 1'b1);
        pin = 1'b0; tick(4);
        chk("R5", "edge flag held after release", flag, 1'b1);
        clear_flag();
        chk("R7", "flag after clear strobe", flag, 1'b0);
    endtask

    task automatic t_edge_held();
        pin = 1'b1; tick(4);
        chk("R5", "edge flag set", flag, 1'b1);
        clear_flag(); tick(4);
        chk("R5", "held level does not re-set", flag, 1'b0);
        pin = 1'b0; tick(3);
    endtask

    task automatic t_falling();
        pol_hi = 1'b0; tick(4); clear_flag();
        pin = 1'b1; tick(4);
        chk("R4", "no flag on rising with low polarity", flag, 1'b0);
        pin = 1'b0; #1;
        chk("R10", "wake low polarity", wake, 1'b1);
        tick(3);
        chk("R4", "flag on falling edge", flag, 1'b1);
        pol_hi = 1'b1; tick(4); clear_flag(); tick(1);
    endtask

    task automatic t_level();
        mode_lvl = 1'b1; pin = 1'b1; tick(3);
        chk("R6", "level flag set", flag, 1'b1);
        clear_flag();
        chk("R6", "clear ignored while asserted", flag, 1'b1);
        tick(2);
        chk("R6", "still pinned", flag, 1'b1);
        pin = 1'b0; tick(2);
        clear_flag();
        chk("R6", "clear works after release", flag, 1'b0);
        mode_lvl = 1'b0; tick(1);
    endtask

    task automatic t_priority();
        pin = 1'b1; tick(2);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        chk("R7", "set wins over clear", flag, 1'b1);
        clear_flag();
        chk("R7", "later clear empties flag", flag, 1'b0);
        pin = 1'b0; tick(3);
    endtask

    task automatic t_irq();
        irq_en = 1'b0; pin = 1'b1; tick(3);
        chk("R8", "flag with irq disabled", flag, 1'b1);
        chk("R8", "no irq while disabled", irq, 1'b0);
        irq_en = 1'b1; #1;
        chk("R8", "irq follows enable", irq, 1'b1);
        pin_en = 1'b0; #1;
        chk("R8", "irq gated by pin enable", irq, 1'b0);
        pin_en = 1'b1; #1;
        clear_flag();
        chk("R8", "irq drops with flag", irq, 1'b0);
        irq_en = 1'b0; pin = 1'b0; tick(3);
    endtask

    task automatic t_enable_asserted();
        pin_en = 1'b0; pin = 1'b1; tick(4);
        chk("R2", "no flag while disabled and asserted", flag, 1'b0);
        pin_en = 1'b1; tick(1);
        chk("R9", "enable on asserted pin sets flag", flag, 1'b1);
        clear_flag(); pin = 1'b0; tick(3);
    endtask

    initial begin
        rst_n = 1'b0; pin = 1'b0; pin_en = 1'b0; pol_hi = 1'b1; mode_lvl = 1'b0;
        irq_en = 1'b0; pull_dis = 1'b0; flag_clr = 1'b0;
        tick(3);
        t_reset();
        rst_n = 1'b1; tick(1);
        t_disabled();
        t_pull();
        t_rising_latency();
        t_edge_held();
        t_falling();
        t_level();
        t_priority();
        t_irq();
        t_enable_asserted();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule